// File: doc/BRIEF.md
# PWM Time-Base Counter with Phase Sync

This block produces the timing reference for one pair of PWM outputs. A W-bit counter steps once per prescaled clock tick and sweeps between zero and a programmable period value. It can count up, count down, count up and then down, or hold its value. Compare logic elsewhere watches the counter value, the direction flag and the zero and period event outputs.

Several instances can be chained into one system. A sync output, chosen from four sources, drives the sync input of the next instance. An instance with phase loading enabled loads its phase value on a hardware or software sync, and in up-down mode it then counts in a chosen direction. This gives a fixed lead or lag against the upstream instance in every cycle.

The period can be written directly to the active register. It can also be written to a shadow copy, which is transferred to the active register while the counter sits at zero. Shadowed writes do not disturb a cycle that is already running.

Top module: `pwm_timebase`

## Requirements
- R1: With `mode`=00 (up), on each tick the counter adds one until it reaches the active period P, then wraps to 0. The sequence is 0,1,...,P,0 and `dir_up` reads 1.
- R2: With `mode`=01 (down), on each tick the counter subtracts one until it reaches 0, then reloads P. The sequence is P,P-1,...,0,P and `dir_up` reads 0.
- R3: With `mode`=10 (up-down), the counter rises from 0 to P and then falls back to 0. It reverses at each end. `dir_up` reads 1 while the counter is rising, including the tick spent at P, and 0 while it is falling, including the tick spent at 0.
- R4: With `mode`=11 (freeze), the counter holds its value.
- R5: `clk_div` sets the tick rate. Code 00 gives a tick on every clock, 01 every 2nd clock, 10 every 4th clock, and 11 also every 4th clock. A sync load restarts the prescaler, so the first step after a sync comes `clk_div`-ratio clocks later.
- R6: With `prd_imm`=1, a write on `prd_wr` updates the active period at that clock edge. With `prd_imm`=0, a write goes only to the shadow copy. The shadow is copied to the active period at every clock edge where the counter reads 0.
- R7: When `phase_en`=1, a pulse on `sync_in` or `sw_sync` loads `phase` into the counter at the next edge, whatever the mode. When `phase_en`=0, both are ignored and counting goes on.
- R8: A sync load in up-down mode sets the direction from `dir_after_sync`: 1 means count up, 0 means count down.
- R9: `evt_zero` is high in every cycle in which the counter reads 0, and `evt_prd` is high in every cycle in which it equals the active period. In up-down mode each event therefore falls on a reversal. A period of 0 holds the counter at 0 with both events high on every cycle.
- R10: `sync_out` follows `sync_sel`. Code 00 passes `sync_in` through, 01 gives the zero event, 10 is high while the counter equals `cmpb`, and 11 holds it low.
- R11: After reset the counter, the active period and the shadow period are all 0, and `evt_zero` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode | input | 2 | Count mode: 00 up, 01 down, 10 up-down, 11 freeze |
| clk_div | input | 2 | Prescaler code: 00 /1, 01 /2, 10 and 11 /4 |
| prd_imm | input | 1 | 1: period writes go to the active register; 0: to the shadow |
| prd_wr | input | 1 | Period write strobe |
| prd_wdata | input | W | Period write value |
| phase | input | W | Value loaded into the counter on a sync |
| phase_en | input | 1 | Enables loading of the phase value on a sync |
| dir_after_sync | input | 1 | Up-down direction after a sync load (1 up) |
| sync_in | input | 1 | Sync pulse from the upstream instance |
| sw_sync | input | 1 | Software sync strobe |
| cmpb | input | W | Compare value for the sync output select |
| sync_sel | input | 2 | Sync output source |
| count | output | W | Counter value |
| dir_up | output | 1 | 1 while counting up |
| evt_zero | output | 1 | Counter equals zero |
| evt_prd | output | 1 | Counter equals the active period |
| sync_out | output | 1 | Sync pulse for the downstream instance |

## Verification
The hardest case to reach is a counter that is already running when a period write or sync lands at a chosen point. The bench gets there by putting every run on a known footing first. It writes the period at once and issues a software sync that loads a known phase, which also resets the prescaler. After that, the expected count, direction and events at the n-th clock are plain integer arithmetic on n, the divide ratio and the period. This arithmetic is swept over all modes, all prescaler codes and several periods, including 0. With the same footing, a shadow write or a sync with loading disabled can be timed to a known counter value, and the bench then checks the exact sequence that follows.

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   mode,
  input  logic [1:0]   clk_div,
  input  logic         prd_imm,
  input  logic         prd_wr,
  input  logic [W-1:0] prd_wdata,
  input  logic [W-1:0] phase,
  input  logic         phase_en,
  input  logic         dir_after_sync,
  input  logic         sync_in,
  input  logic         sw_sync,
  input  logic [W-1:0] cmpb,
  input  logic [1:0]   sync_sel,
  output logic [W-1:0] count,
  output logic         dir_up,
  output logic         evt_zero,
  output logic         evt_prd,
  output logic         sync_out
);
  localparam logic [1:0] M_UP = 2'b00, M_DN = 2'b01, M_UD = 2'b10;

  logic [W-1:0] cnt_q, cnt_d, prd_act, prd_sh;
  logic         dir_q, dir_d;
  logic [1:0]   pre_q, pre_last;

  wire sync_ev = phase_en & (sync_in | sw_sync);
  wire at_zero = (cnt_q == '0);

  always_comb
    case (clk_div)
      2'b00:   pre_last = 2'd0;
      2'b01:   pre_last = 2'd1;
      default: pre_last = 2'd3;
    endcase

  wire tick = (pre_q == pre_last);

  always_comb begin
    cnt_d = cnt_q;
    dir_d = dir_q;
    if (sync_ev) begin
      cnt_d = phase;
      dir_d = (mode == M_UP) ? 1'b1 : (mode == M_DN) ? 1'b0 : dir_after_sync;
    end else if (tick) begin
      case (mode)
        M_UP: begin
          cnt_d = (cnt_q >= prd_act) ? '0 : cnt_q + W'(1);
          dir_d = 1'b1;
        end
        M_DN: begin
          cnt_d = (at_zero || cnt_q > prd_act) ? prd_act : cnt_q - W'(1);
          dir_d = 1'b0;
        end
        M_UD: begin
          if (dir_q) begin
            if (cnt_q >= prd_act) begin
              dir_d = 1'b0;
              cnt_d = at_zero ? '0 : cnt_q - W'(1);
            end else
              cnt_d = cnt_q + W'(1);
          end else if (at_zero) begin
            dir_d = 1'b1;
            cnt_d = (prd_act == '0) ? '0 : W'(1);
          end else
            cnt_d = cnt_q - W'(1);
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt_q <= '0;
      dir_q <= 1'b1;
      pre_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      dir_q <= dir_d;
      pre_q <= (sync_ev || tick) ? 2'd0 : pre_q + 2'd1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      prd_act <= '0;
      prd_sh  <= '0;
    end else begin
      if (prd_wr) prd_sh <= prd_wdata;
      if (prd_wr && prd_imm) prd_act <= prd_wdata;
      else if (at_zero)      prd_act <= prd_sh;
    end

  assign count    = cnt_q;
  assign dir_up   = (mode == M_UP) ? 1'b1 : (mode == M_DN) ? 1'b0 : dir_q;
  assign evt_zero = at_zero;
  assign evt_prd  = (cnt_q == prd_act);

  always_comb
    case (sync_sel)
      2'b00:   sync_out = sync_in;
      2'b01:   sync_out = at_zero;
      2'b10:   sync_out = (cnt_q == cmpb);
      default: sync_out = 1'b0;
    endcase
endmodule

module pwm_timebase_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic [1:0]   mode,
  input logic         phase_en,
  input logic         sync_in,
  input logic         sw_sync,
  input logic         prd_wr,
  input logic         dir_after_sync,
  input logic [W-1:0] phase,
  input logic [W-1:0] count,
  input logic [W-1:0] prd_act,
  input logic         dir_up
);
  wire sev = phase_en && (sync_in || sw_sync);

  a_r4_freeze_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b11 && !sev) |=> $stable(count));

  a_r7_sync_loads_phase: assert property (@(posedge clk) disable iff (!rst_n)
    sev |=> (count == $past(phase)));

  a_r1_up_step: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b00 && !sev) |=>
      (count == $past(count) || count == $past(count) + W'(1) || count == '0));

  a_r6_shadow_waits_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (!prd_wr && count != '0) |=> $stable(prd_act));

  a_r8_dir_after_sync: assert property (@(posedge clk) disable iff (!rst_n)
    (sev && mode == 2'b10) |=> (mode != 2'b10 || dir_up == $past(dir_after_sync)));
endmodule

bind pwm_timebase pwm_timebase_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .phase_en(phase_en),
  .sync_in(sync_in), .sw_sync(sw_sync), .prd_wr(prd_wr),
  .dir_after_sync(dir_after_sync), .phase(phase), .count(count),
  .prd_act(prd_act), .dir_up(dir_up)
);

// File: tb/pwm_timebase_test.sv
module pwm_timebase_test;
  localparam int W = 16;
  logic clk = 0, rst_n = 0;
  logic [1:0] mode = 0, clk_div = 0, sync_sel = 0;
  logic prd_imm = 1, prd_wr = 0, phase_en = 0, dir_after_sync = 1, sync_in = 0, sw_sync = 0;
  logic [W-1:0] prd_wdata = 0, phase = 0, cmpb = 0;
  logic [W-1:0] count;
  logic dir_up, evt_zero, evt_prd, sync_out;
  int vecs = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pwm_timebase #(.W(W)) uut (.*);

  task automatic chk(string req, int act, int exp);
    vecs++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
    end
  endtask

  task automatic start(logic [1:0] m, logic [1:0] dc, int p, int ph, logic dsync, logic [1:0] ss);
    @(negedge clk);
    mode = m; clk_div = dc; prd_imm = 1; prd_wr = 1; prd_wdata = W'(p);
    phase_en = 1; phase = W'(ph); dir_after_sync = dsync; sw_sync = 1; sync_sel = ss; cmpb = 2;
    @(negedge clk);
    prd_wr = 0; sw_sync = 0; phase_en = 0;
  endtask

  task automatic sweep(logic [1:0] m, logic [1:0] dc, int p);
    int d = (dc == 0) ? 1 : (dc == 1) ? 2 : 4;
    int len = d * (2 * p + 2) * 2;
    logic [1:0] ss = (m == 2'b01) ? 2'b10 : 2'b01;
    start(m, dc, p, (m == 2'b01) ? p : 0, 1'b1, ss);
    for (int n = 0; n < len; n++) begin
      int k = n / d;
      int ec, ed;
      if (m == 2'b00) begin ec = k % (p + 1); ed = 1; end
      else if (m == 2'b01) begin ec = p - (k % (p + 1)); ed = 0; end
      else if (p == 0) begin ec = 0; ed = -1; end
      else begin
        int t = k % (2 * p);
        ec = (t <= p) ? t : 2 * p - t;
        ed = (k == 0 || (t >= 1 && t <= p)) ? 1 : 0;
      end
      if (m == 2'b00) chk("R1 up count", int'(count), ec);
      else if (m == 2'b01) chk("R2 down count", int'(count), ec);
      else chk("R3 up-down count", int'(count), ec);
      if (ed >= 0) chk("R3 dir_up", int'(dir_up), ed);
      chk("R9 evt_zero", int'(evt_zero), int'(ec == 0));
      chk("R9 evt_prd", int'(evt_prd), int'(ec == p));
      if (ss == 2'b01) chk("R10 sync_out zero", int'(sync_out), int'(ec == 0));
      else chk("R10 sync_out cmpb", int'(sync_out), int'(ec == 2));
      if (d > 1) chk("R5 prescale", int'(count), ec);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R11 reset count", int'(count), 0);
    chk("R11 reset evt_zero", int'(evt_zero), 1);

    for (int m = 0; m < 3; m++)
      for (int dc = 0; dc < 4; dc++) begin
        sweep(2'(m), 2'(dc), 0);
        sweep(2'(m), 2'(dc), 1);
        sweep(2'(m), 2'(dc), 2);
        sweep(2'(m), 2'(dc), 5);
        sweep(2'(m), 2'(dc), 7);
      end

    // R4 freeze
    start(2'b11, 2'b00, 7, 3, 1'b1, 2'b11);
    for (int i = 0; i < 10; i++) begin
      chk("R4 freeze hold", int'(count), 3);
      @(negedge clk);
    end

    // R8 direction after sync = down
    start(2'b10, 2'b00, 5, 3, 1'b0, 2'b11);
    begin
      int exp_c[6] = '{3, 2, 1, 0, 1, 2};
      int exp_d[6] = '{0, 0, 0, 0, 1, 1};
      for (int i = 0; i < 6; i++) begin
        chk("R8 count after down sync", int'(count), exp_c[i]);
        chk("R8 dir after down sync", int'(dir_up), exp_d[i]);
        @(negedge clk);
      end
    end

    // R6 shadow write lands only at zero
    start(2'b00, 2'b00, 5, 0, 1'b1, 2'b11);
    @(negedge clk);
    prd_imm = 0; prd_wr = 1; prd_wdata = 3;
    @(negedge clk);
    prd_wr = 0;
    begin
      int exp_s[10] = '{2, 3, 4, 5, 0, 1, 2, 3, 0, 1};
      for (int i = 0; i < 10; i++) begin
        chk("R6 shadow sequence", int'(count), exp_s[i]);
        @(negedge clk);
      end
    end

    // R6 immediate write
    start(2'b00, 2'b00, 5, 0, 1'b1, 2'b11);
    @(negedge clk);
    prd_imm = 1; prd_wr = 1; prd_wdata = 2;
    @(negedge clk);
    prd_wr = 0;
    begin
      int exp_i[5] = '{2, 0, 1, 2, 0};
      for (int i = 0; i < 5; i++) begin
        chk("R6 immediate sequence", int'(count), exp_i[i]);
        @(negedge clk);
      end
    end

    // R7 sync ignored when phase loading is off; R10 pass-through and disabled
    start(2'b00, 2'b00, 7, 0, 1'b1, 2'b00);
    @(negedge clk);
    @(negedge clk);
    chk("R7 pre-sync count", int'(count), 2);
    phase_en = 0; phase = 6; sync_in = 1;
    #1 chk("R10 sync_out passes sync_in", int'(sync_out), 1);
    sync_sel = 2'b11;
    #1 chk("R10 sync_out disabled", int'(sync_out), 0);
    @(negedge clk);
    sync_in = 0; sync_sel = 2'b00;
    chk("R7 sync ignored", int'(count), 3);

    // R7 hardware sync loads phase
    phase_en = 1; phase = 6; sync_in = 1;
    @(negedge clk);
    sync_in = 0; phase_en = 0;
    chk("R7 sync_in loads phase", int'(count), 6);
    @(negedge clk);
    chk("R7 count after load", int'(count), 7);
    @(negedge clk);
    chk("R7 wrap after load", int'(count), 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end
endmodule